// File: doc/BRIEF.md
# UART Register and Interrupt Core

This block is the host-facing register file of a classic 8-byte UART. A host reads and writes single bytes at offsets 0 to 7, and only the low three address bits matter. The core holds line, modem and divisor settings and passes them to a separate serializer. It also keeps the line-status and modem-status bits. It merges five interrupt causes into one prioritized identification code and one interrupt pin. Reads have side effects: some reads pop received data, and some clear status bits.

Transmit data leaves through a valid/ready stream. `tx_valid` stays high from the holding-register write until the serializer takes the byte with `tx_ready`. The holding register then reads as empty again. A second write before that handshake replaces the waiting byte. The receive side has no back-pressure. A byte on `rx_valid` is always taken, and a byte that finds no room is reported as an overrun instead of stalling the sender. A receive queue of `RX_DEPTH` entries is used when FIFO mode is on. Otherwise a single holding byte is used.

Top module: `uart_regcore`

## Requirements
- R1: After reset these values hold:
  - line status 0x60 (bit 6 transmitter empty, bit 5 holding empty);
  - modem status 0xB0 while `modem_in` = 4'b1011;
  - modem control 0x08 (bit 3 enables the interrupt pin);
  - line control, scratch and enable register 0x00;
  - identification 0x01;
  - divisor 0x000C, and `irq` low.
- R2: With line-control bit 7 set, offsets 0 and 1 read and write the divisor low and high bytes, and `divisor` shows {high, low}. A write to offset 0 then does not load the transmit byte.
- R3: Line-control bits drive the serializer settings: bits 1:0 drive `word_len`, bit 2 drives `stop_two`, bit 3 drives `parity_en` and bit 4 drives `parity_even` (set means even).
- R4: A write to offset 0 (bit 7 clear) loads `tx_data`. It raises `tx_valid` and clears line-status bits 5 and 6 and any pending transmit-empty interrupt. The `tx_valid`/`tx_ready` handshake sets bit 5 again and marks transmit-empty pending. Bit 6 returns once `tx_busy` is low.
- R5: With FIFOs off, a received byte sets line-status bit 0. A byte arriving while bit 0 is set sets overrun bit 1 and replaces the held byte. A read of offset 0 clears bit 0.
- R6: A write to offset 2 with bit 0 set turns on FIFO mode, and identification bits 7:6 then read 11. Bytes are read back in arrival order, up to `RX_DEPTH` of them. A byte arriving at a full queue sets overrun and is discarded.
- R7: A line-status read returns the current value, then clears break bit 4 (set by `rx_break`) and overrun bit 1.
- R8: A read of offset 2 clears the pending transmit-empty interrupt only when it returns that cause's code 0x2 in bits 3:0.
- R9: Identification bits 3:0 report the highest enabled cause, highest first:
  - 0x6 for line errors (enable bit 2);
  - 0xC for receive timeout, or 0x4 for data ready (enable bit 0);
  - 0x2 for transmit-empty (enable bit 1);
  - 0x0 for a modem change (enable bit 3);
  - 0x1 when nothing is pending.
- R10: `irq` is high when an enabled cause is pending and modem-control bit 3 is set. Setting enable bit 1 while the holding register is empty marks transmit-empty pending.
- R11: An `rx_timeout` pulse while in FIFO mode with data queued reports code 0xC. The next read of offset 0 clears it.
- R12: Modem status bits 7:4 follow `modem_in` {DCD, RI, DSR, CTS}. Bits 0, 1 and 3 latch changes of CTS, DSR and DCD. Bit 2 latches RI falling. A read of offset 6 clears the latched bits.
- R13: Writes to offsets 5 and 6 have no effect. The scratch byte at offset 7 reads back what was written.
- R14: A write to offset 2 with bit 1 set empties the receive queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; side effects at the end of the cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Break detected pulse |
| rx_timeout | input | 1 | Receive idle-timeout pulse |
| tx_valid | output | 1 | Transmit byte waiting |
| tx_ready | input | 1 | Serializer accepts the byte |
| tx_data | output | 8 | Transmit byte |
| tx_busy | input | 1 | Serializer still shifting |
| modem_in | input | 4 | {DCD, RI, DSR, CTS}, high means asserted |
| dtr_o | output | 1 | Modem-control bit 0 |
| rts_o | output | 1 | Modem-control bit 1 |
| divisor | output | 16 | Baud divisor |
| word_len | output | 2 | Data bits minus 5 |
| stop_two | output | 1 | Two stop bits |
| parity_en | output | 1 | Parity enabled |
| parity_even | output | 1 | Even parity when set |
| irq | output | 1 | Interrupt request |

## Verification
Most internal faults in this core surface in the next register read, one cycle after the update.
- A stale or wrongly cleared status bit shows in the next line-status or identification read.
- A mis-ordered queue pointer shows as a wrong byte on the next data read.
- A priority fault shows as a wrong code in bits 3:0, even while `irq` still looks correct.
- A lost transmit-pending flag shows only once its enable bit is set. For that reason the tests reorder enables and causes deliberately and read each code twice, to see whether the first read cleared it.

// File: rtl/uart_regcore_pkg.sv
package uart_regcore_pkg;

  typedef enum logic [3:0] {
    IID_NONE    = 4'b0001,
    IID_LINE    = 4'b0110,
    IID_RXDATA  = 4'b0100,
    IID_TIMEOUT = 4'b1100,
    IID_THRE    = 4'b0010,
    IID_MODEM   = 4'b0000
  } iid_e;

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_IER  = 3'd1;
  localparam logic [2:0] OFS_IIR  = 3'd2;
  localparam logic [2:0] OFS_LCR  = 3'd3;
  localparam logic [2:0] OFS_MCR  = 3'd4;
  localparam logic [2:0] OFS_LSR  = 3'd5;
  localparam logic [2:0] OFS_MSR  = 3'd6;
  localparam logic [2:0] OFS_SCR  = 3'd7;

endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    step = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R6
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R6
  fifo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> full);

endmodule

// File: rtl/uart_modem_status.sv
module uart_modem_status #(
  parameter int NLINES = 4,
  parameter int RI_IDX = 2,
  parameter logic [NLINES-1:0] RESET_LINES = 4'b1011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] lines_i,
  input  logic              clr_delta,
  output logic [2*NLINES-1:0] msr,
  output logic              change
);
  logic [NLINES-1:0] cur_q, delta_q, evt;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    if (i == RI_IDX) begin : g_trail
      assign evt[i] = cur_q[i] & ~lines_i[i];
    end else begin : g_edge
      assign evt[i] = cur_q[i] ^ lines_i[i];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) delta_q[i] <= 1'b0;
      else        delta_q[i] <= evt[i] | (delta_q[i] & ~clr_delta);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cur_q <= RESET_LINES;
    else        cur_q <= lines_i;
  end

  assign msr    = {cur_q, delta_q};
  assign change = |delta_q;

  // R12
  modem_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_delta && evt == '0) |=> (delta_q == '0));

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_regcore_pkg::*;
(
  input  logic [3:0] ier,
  input  logic       fifo_en,
  input  logic       line_evt,
  input  logic       timeout_evt,
  input  logic       data_evt,
  input  logic       thre_evt,
  input  logic       modem_evt,
  output logic [7:0] iir,
  output logic       pending
);
  iid_e id;

  always_comb begin
    if (ier[2] && line_evt)         id = IID_LINE;
    else if (ier[0] && timeout_evt) id = IID_TIMEOUT;
    else if (ier[0] && data_evt)    id = IID_RXDATA;
    else if (ier[1] && thre_evt)    id = IID_THRE;
    else if (ier[3] && modem_evt)   id = IID_MODEM;
    else                            id = IID_NONE;
  end

  assign iir     = {{2{fifo_en}}, 2'b00, id};
  assign pending = ~id[0];

endmodule

// File: rtl/uart_regcore.sv
module uart_regcore
  import uart_regcore_pkg::*;
#(
  parameter int          RX_DEPTH  = 16,
  parameter logic [15:0] DIV_RESET = 16'h000C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_break,
  input  logic        rx_timeout,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  input  logic        tx_busy,
  input  logic [3:0]  modem_in,
  output logic        dtr_o,
  output logic        rts_o,
  output logic [15:0] divisor,
  output logic [1:0]  word_len,
  output logic        stop_two,
  output logic        parity_en,
  output logic        parity_even,
  output logic        irq
);
  localparam int CW = $clog2(RX_DEPTH + 1);

  logic [3:0] ier_q;
  logic [7:0] lcr_q, scr_q, dll_q, dlm_q, thr_q, rbr_q;
  logic [4:0] mcr_q;
  logic       fifo_en_q, thre_q, temt_q, thr_pend_q, dr_q, oe_q, bi_q, to_pend_q;

  logic       dlab;
  logic       wr_thr, wr_dll, wr_dlm, wr_ier, wr_fcr, wr_lcr, wr_mcr, wr_scr;
  logic       rd_rbr, rd_iir, rd_lsr, rd_msr;
  logic       tx_fire, ovr_evt, dr;
  logic       f_clr, f_push, f_pop, f_full, f_empty;
  logic [7:0] f_dout, lsr, msr, iir;
  logic [CW-1:0] f_count;
  logic       modem_chg, int_pending;

  assign dlab   = lcr_q[7];
  assign wr_thr = bus_wr && bus_addr == OFS_DATA && !dlab;
  assign wr_dll = bus_wr && bus_addr == OFS_DATA && dlab;
  assign wr_ier = bus_wr && bus_addr == OFS_IER && !dlab;
  assign wr_dlm = bus_wr && bus_addr == OFS_IER && dlab;
  assign wr_fcr = bus_wr && bus_addr == OFS_IIR;
  assign wr_lcr = bus_wr && bus_addr == OFS_LCR;
  assign wr_mcr = bus_wr && bus_addr == OFS_MCR;
  assign wr_scr = bus_wr && bus_addr == OFS_SCR;
  assign rd_rbr = bus_rd && bus_addr == OFS_DATA && !dlab;
  assign rd_iir = bus_rd && bus_addr == OFS_IIR;
  assign rd_lsr = bus_rd && bus_addr == OFS_LSR;
  assign rd_msr = bus_rd && bus_addr == OFS_MSR;

  assign tx_valid = ~thre_q;
  assign tx_data  = thr_q;
  assign tx_fire  = tx_valid && tx_ready;

  assign f_clr  = wr_fcr && (bus_wdata[1] || (bus_wdata[0] != fifo_en_q));
  assign f_push = rx_valid && fifo_en_q;
  assign f_pop  = rd_rbr && fifo_en_q;
  assign dr     = fifo_en_q ? !f_empty : dr_q;
  assign ovr_evt = rx_valid && (fifo_en_q ? (f_full && !f_pop) : (dr_q && !rd_rbr));

  uart_rx_fifo #(.DEPTH(RX_DEPTH), .WIDTH(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(f_clr), .push(f_push), .pop(f_pop),
    .din(rx_data), .dout(f_dout), .count(f_count), .full(f_full), .empty(f_empty)
  );

  uart_modem_status #(.NLINES(4), .RI_IDX(2), .RESET_LINES(4'b1011)) u_msr (
    .clk(clk), .rst_n(rst_n), .lines_i(modem_in), .clr_delta(rd_msr),
    .msr(msr), .change(modem_chg)
  );

  uart_irq_prio u_prio (
    .ier(ier_q), .fifo_en(fifo_en_q), .line_evt(oe_q | bi_q),
    .timeout_evt(to_pend_q), .data_evt(dr), .thre_evt(thr_pend_q),
    .modem_evt(modem_chg), .iir(iir), .pending(int_pending)
  );

  assign lsr = {1'b0, temt_q, thre_q, bi_q, 2'b00, oe_q, dr};

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ier_q     <= '0;
      lcr_q     <= '0;
      mcr_q     <= 5'b01000;
      scr_q     <= '0;
      dll_q     <= DIV_RESET[7:0];
      dlm_q     <= DIV_RESET[15:8];
      fifo_en_q <= 1'b0;
    end else begin
      if (wr_ier) ier_q     <= bus_wdata[3:0];
      if (wr_lcr) lcr_q     <= bus_wdata;
      if (wr_mcr) mcr_q     <= bus_wdata[4:0];
      if (wr_scr) scr_q     <= bus_wdata;
      if (wr_dll) dll_q     <= bus_wdata;
      if (wr_dlm) dlm_q     <= bus_wdata;
      if (wr_fcr) fifo_en_q <= bus_wdata[0];
    end
  end

  // transmit side
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q      <= '0;
      thre_q     <= 1'b1;
      temt_q     <= 1'b1;
      thr_pend_q <= 1'b0;
    end else begin
      if (wr_thr) begin
        thr_q  <= bus_wdata;
        thre_q <= 1'b0;
        temt_q <= 1'b0;
      end else begin
        if (tx_fire) thre_q <= 1'b1;
        temt_q <= thre_q & ~tx_busy;
      end
      if (wr_thr)
        thr_pend_q <= 1'b0;
      else if (tx_fire)
        thr_pend_q <= 1'b1;
      else if (rd_iir && iir[3:0] == IID_THRE)
        thr_pend_q <= 1'b0;
      else if (wr_ier && bus_wdata[1] && !ier_q[1] && thre_q)
        thr_pend_q <= 1'b1;
    end
  end

  // receive side and line status
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rbr_q     <= '0;
      dr_q      <= 1'b0;
      oe_q      <= 1'b0;
      bi_q      <= 1'b0;
      to_pend_q <= 1'b0;
    end else begin
      if (rx_valid && !fifo_en_q) rbr_q <= rx_data;
      if (wr_fcr)
        dr_q <= 1'b0;
      else if (rx_valid && !fifo_en_q)
        dr_q <= 1'b1;
      else if (rd_rbr)
        dr_q <= 1'b0;
      if (ovr_evt)     oe_q <= 1'b1;
      else if (rd_lsr) oe_q <= 1'b0;
      if (rx_break)    bi_q <= 1'b1;
      else if (rd_lsr) bi_q <= 1'b0;
      if (rd_rbr || f_empty || !fifo_en_q || f_clr)
        to_pend_q <= 1'b0;
      else if (rx_timeout)
        to_pend_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFS_DATA: bus_rdata = dlab ? dll_q : (fifo_en_q ? f_dout : rbr_q);
      OFS_IER:  bus_rdata = dlab ? dlm_q : {4'b0000, ier_q};
      OFS_IIR:  bus_rdata = iir;
      OFS_LCR:  bus_rdata = lcr_q;
      OFS_MCR:  bus_rdata = {3'b000, mcr_q};
      OFS_LSR:  bus_rdata = lsr;
      OFS_MSR:  bus_rdata = msr;
      default:  bus_rdata = scr_q;
    endcase
  end

  assign divisor     = {dlm_q, dll_q};
  assign word_len    = lcr_q[1:0];
  assign stop_two    = lcr_q[2];
  assign parity_en   = lcr_q[3];
  assign parity_even = lcr_q[4];
  assign dtr_o       = mcr_q[0];
  assign rts_o       = mcr_q[1];
  assign irq         = mcr_q[3] & int_pending;

  // R4
  thr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_thr |=> (!lsr[5] && !lsr[6] && tx_valid));
  // R7
  lsr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && !ovr_evt && !rx_break) |=> (!lsr[1] && !lsr[4]));
  // R8
  iir_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_iir && iir[3:0] != IID_THRE && thr_pend_q && !wr_thr) |=> thr_pend_q);
  // R5
  rx_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !fifo_en_q && dr_q && !rd_rbr) |=> lsr[1]);
  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mcr && !bus_wdata[3]) |=> !irq);

endmodule

// File: tb/uart_regcore_tb.sv
module uart_regcore_tb;
  localparam int FDEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic rx_valid = 1'b0, rx_break = 1'b0, rx_timeout = 1'b0;
  logic [7:0] rx_data = '0;
  logic tx_valid, tx_ready = 1'b0, tx_busy = 1'b0;
  logic [7:0] tx_data;
  logic [3:0] modem_in = 4'b1011;
  logic dtr_o, rts_o, stop_two, parity_en, parity_even, irq;
  logic [15:0] divisor;
  logic [1:0] word_len;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_regcore #(.RX_DEPTH(FDEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_break(rx_break), .rx_timeout(rx_timeout), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_busy(tx_busy), .modem_in(modem_in), .dtr_o(dtr_o), .rts_o(rts_o),
    .divisor(divisor), .word_len(word_len), .stop_two(stop_two), .parity_en(parity_en),
    .parity_even(parity_even), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
    chk(tag, {8'h00, v}, {8'h00, exp});
  endtask

  task automatic rx_send(input logic [7:0] d);
    @(negedge clk); rx_valid = 1'b1; rx_data = d;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic pulse_break();
    @(negedge clk); rx_break = 1'b1;
    @(negedge clk); rx_break = 1'b0;
  endtask

  task automatic pulse_timeout();
    @(negedge clk); rx_timeout = 1'b1;
    @(negedge clk); rx_timeout = 1'b0;
  endtask

  task automatic tx_take();
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 divisor", divisor, 16'h000C);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    rd_chk(3'd5, 8'h60, "R1 lsr");
    rd_chk(3'd6, 8'hB0, "R1 msr");
    rd_chk(3'd4, 8'h08, "R1 mcr");
    rd_chk(3'd3, 8'h00, "R1 lcr");
    rd_chk(3'd7, 8'h00, "R1 scr");
    rd_chk(3'd1, 8'h00, "R1 ier");
    rd_chk(3'd2, 8'h01, "R1 iir");
  endtask

  task automatic t_divisor();
    wr(3'd3, 8'h80);
    wr(3'd0, 8'h34);
    wr(3'd1, 8'h12);
    chk("R2 divisor out", divisor, 16'h1234);
    chk("R2 no tx load", {15'd0, tx_valid}, 16'd0);
    rd_chk(3'd0, 8'h34, "R2 dll read");
    rd_chk(3'd1, 8'h12, "R2 dlm read");
    wr(3'd3, 8'h1F);
    chk("R3 fields", {11'd0, parity_even, parity_en, stop_two, word_len}, 16'h001F);
    rd_chk(3'd1, 8'h00, "R2 ier visible when bit7 clear");
    wr(3'd3, 8'h0B);
    chk("R3 odd parity", {11'd0, parity_even, parity_en, stop_two, word_len}, 16'h000B);
    wr(3'd3, 8'h03);
  endtask

  task automatic t_transmit();
    wr(3'd0, 8'h5A);
    chk("R4 tx_valid", {15'd0, tx_valid}, 16'd1);
    chk("R4 tx_data", {8'd0, tx_data}, 16'h005A);
    rd_chk(3'd5, 8'h00, "R4 thre temt cleared");
    @(negedge clk); tx_ready = 1'b1; tx_busy = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    chk("R4 tx_valid dropped", {15'd0, tx_valid}, 16'd0);
    rd_chk(3'd5, 8'h20, "R4 thre back, shifting");
    @(negedge clk); tx_busy = 1'b0;
    rd_chk(3'd5, 8'h60, "R4 temt back");
  endtask

  task automatic t_iir_select();
    wr(3'd1, 8'h00);
    wr(3'd1, 8'h03);
    rx_send(8'h11);
    rd_chk(3'd2, 8'h04, "R9 data over thre");
    rd_chk(3'd0, 8'h11, "R5 data byte");
    rd_chk(3'd2, 8'h02, "R8 thre kept after other id read");
    rd_chk(3'd2, 8'h01, "R8 thre cleared by its own read");
    wr(3'd1, 8'h00);
    wr(3'd1, 8'h02);
    rd_chk(3'd2, 8'h02, "R10 enable marks thre");
    wr(3'd0, 8'h77);
    rd_chk(3'd2, 8'h01, "R4 write clears pending");
    tx_take();
    rd_chk(3'd2, 8'h02, "R4 handshake sets pending");
    rd_chk(3'd2, 8'h01, "R8 clear");
    wr(3'd1, 8'h00);
  endtask

  task automatic t_irq_gate();
    wr(3'd1, 8'h02);
    chk("R10 irq high", {15'd0, irq}, 16'd1);
    wr(3'd4, 8'h03);
    chk("R10 irq gated", {15'd0, irq}, 16'd0);
    chk("R10 dtr rts", {14'd0, rts_o, dtr_o}, 16'd3);
    wr(3'd4, 8'h08);
    chk("R10 irq again", {15'd0, irq}, 16'd1);
    rd_chk(3'd2, 8'h02, "R10 iir");
    chk("R10 irq after clear", {15'd0, irq}, 16'd0);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_line();
    wr(3'd1, 8'h05);
    pulse_break();
    rx_send(8'h22);
    rd_chk(3'd2, 8'h06, "R9 line highest");
    rd_chk(3'd5, 8'h71, "R7 lsr with break");
    rd_chk(3'd2, 8'h04, "R7 break cleared");
    rd_chk(3'd0, 8'h22, "R5 byte");
    rd_chk(3'd2, 8'h01, "R9 none");
    wr(3'd1, 8'h00);
  endtask

  task automatic t_overrun();
    rx_send(8'h41);
    rx_send(8'h42);
    rd_chk(3'd5, 8'h63, "R5 overrun");
    rd_chk(3'd5, 8'h61, "R7 overrun cleared");
    rd_chk(3'd0, 8'h42, "R5 replaced");
    rd_chk(3'd5, 8'h60, "R5 dr cleared");
  endtask

  task automatic t_modem();
    wr(3'd1, 8'h08);
    @(negedge clk); modem_in = 4'b1010;
    rd_chk(3'd2, 8'h00, "R9 modem code");
    wr(3'd1, 8'h0A);
    rd_chk(3'd2, 8'h02, "R9 thre over modem");
    rd_chk(3'd2, 8'h00, "R8 thre cleared, modem left");
    rd_chk(3'd6, 8'hA1, "R12 cts delta");
    rd_chk(3'd6, 8'hA0, "R12 delta cleared");
    rd_chk(3'd2, 8'h01, "R12 none");
    @(negedge clk); modem_in = 4'b1110;
    rd_chk(3'd6, 8'hE0, "R12 ri rise no delta");
    @(negedge clk); modem_in = 4'b1010;
    rd_chk(3'd6, 8'hA4, "R12 ri fall");
    @(negedge clk); modem_in = 4'b1011;
    rd_chk(3'd6, 8'hB1, "R12 cts back");
    rd_chk(3'd6, 8'hB0, "R12 clear");
    wr(3'd1, 8'h00);
  endtask

  task automatic t_readonly();
    wr(3'd5, 8'hFF);
    wr(3'd6, 8'h00);
    rd_chk(3'd5, 8'h60, "R13 lsr unchanged");
    rd_chk(3'd6, 8'hB0, "R13 msr unchanged");
    wr(3'd7, 8'hA5);
    rd_chk(3'd7, 8'hA5, "R13 scratch");
  endtask

  task automatic t_fifo();
    wr(3'd2, 8'h01);
    rd_chk(3'd2, 8'hC1, "R6 fifo id bits");
    for (int i = 0; i < FDEPTH; i++) rx_send(8'(8'h30 + i));
    rx_send(8'hEE);
    rd_chk(3'd5, 8'h63, "R6 full overrun");
    for (int i = 0; i < FDEPTH; i++) rd_chk(3'd0, 8'(8'h30 + i), "R6 order");
    rd_chk(3'd5, 8'h60, "R6 drained");
    rx_send(8'h50);
    rx_send(8'h51);
    wr(3'd1, 8'h01);
    rd_chk(3'd2, 8'hC4, "R11 data before timeout");
    pulse_timeout();
    rd_chk(3'd2, 8'hCC, "R11 timeout");
    rd_chk(3'd0, 8'h50, "R11 byte");
    rd_chk(3'd2, 8'hC4, "R11 timeout cleared");
    wr(3'd2, 8'h03);
    rd_chk(3'd5, 8'h60, "R14 cleared");
    rd_chk(3'd2, 8'hC1, "R14 none");
    wr(3'd2, 8'h00);
    wr(3'd1, 8'h00);
    rd_chk(3'd2, 8'h01, "R6 fifo off");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_divisor();
    t_transmit();
    t_iir_select();
    t_irq_gate();
    t_line();
    t_overrun();
    t_modem();
    t_readonly();
    t_fifo();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule